// File: doc/BRIEF.md
# Embedded Operation Status Flag Generator

This block forms the three status bits that a flash-style memory returns on a status read while an internal program or erase runs or is suspended. The bits are a polling bit, a first toggle bit and a second toggle bit. A controller supplies a 3-bit operating mode, the sector addressed by the current read, a mask of the sectors that are being erased or are erase-suspended, bit 7 of the byte being programmed, the three array data bits that a plain read would return, and a read strobe.

A registered mode state machine selects how the flags are formed. It has five states: ST_IDLE, ST_PROG, ST_ERASE, ST_SUSP_RD and ST_SUSP_PG. On every clock edge it moves to the state that the mode input names. Mode codes 0, 1, 2, 3 and 4 select ST_IDLE, ST_PROG, ST_ERASE, ST_SUSP_RD and ST_SUSP_PG. Codes 5 to 7 select ST_IDLE. Any state can move to any other state in one edge.

Each toggle bit comes from its own flip-flop. The flip-flop inverts when the clock samples a rising edge of the read strobe and its condition holds. The first toggle bit inverts on any read in ST_PROG, ST_ERASE or ST_SUSP_PG. The second inverts only when the read hits a masked sector in ST_ERASE or ST_SUSP_RD. With the two bits together, software can tell a suspended erase from an active one and can find which sectors are being erased.

Top module: `estat_flags_top`

## Requirements
- R1: While reset is asserted and in ST_IDLE, the status outputs {poll_o, tog1_o, tog2_o} equal {arr_d7_i, arr_d6_i, arr_d2_i}, and both toggle flip-flops hold 0.
- R2: A new mode code takes effect on the status outputs only after the next rising clock edge. Codes 5 to 7 act as idle (code 0).
- R3: In ST_PROG (code 1), poll_o is the inverse of prog_d7_i, tog1_o shows the first toggle flip-flop, and tog2_o is 1.
- R4: In ST_ERASE (code 2), poll_o is 0 and the first toggle flip-flop inverts on every read.
- R5: In ST_ERASE, the second toggle flip-flop inverts on a read only when erase_mask_i bit rd_sector_i is 1. On any other read it keeps its value.
- R6: In ST_SUSP_RD (code 3), poll_o and tog1_o are both 1. The second toggle flip-flop inverts on reads that hit a masked sector.
- R7: In ST_SUSP_PG (code 4), poll_o is the inverse of prog_d7_i, tog1_o toggles on every read, and tog2_o is 1.
- R8: A flip-flop inverts at most once per strobe pulse, on the first clock edge that samples rd_stb_i high after it was low. Holding the strobe high does nothing more.
- R9: Both toggle flip-flops clear to 0 on any clock edge at which the state is ST_IDLE.
- R10: In ST_SUSP_RD the first toggle flip-flop keeps its value, so an erase that resumes shows the value it had when it was suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operating mode code |
| rd_stb_i | input | 1 | Read strobe; its rising edge marks a read |
| rd_sector_i | input | SEC_W | Sector addressed by the current read |
| erase_mask_i | input | NUM_SECTORS | One bit per sector that is being erased or is suspended |
| prog_d7_i | input | 1 | True bit 7 of the byte being programmed |
| arr_d7_i | input | 1 | Array data bit 7, passed through when idle |
| arr_d6_i | input | 1 | Array data bit 6, passed through when idle |
| arr_d2_i | input | 1 | Array data bit 2, passed through when idle |
| poll_o | output | 1 | Polling bit |
| tog1_o | output | 1 | First toggle bit |
| tog2_o | output | 1 | Second toggle bit |

## Verification
A mode change reaches the outputs one clock edge later, because only the state register lies on that path. A strobe rise inverts a toggle bit at the first edge that samples it high. The sector, mask and programmed-data inputs act on the outputs combinationally within the same cycle. Each table step drives its mode and data at a falling edge with the strobe low and waits one edge so that the state settles. It then raises the strobe for one edge and compares the outputs at the next falling edge. The directed tests also sample just before the mode edge and across several edges of a held strobe, which checks that no result comes early and that no toggle is repeated.

// File: rtl/estat_pkg.sv
package estat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PROG    = 3'd1,
        ST_ERASE   = 3'd2,
        ST_SUSP_RD = 3'd3,
        ST_SUSP_PG = 3'd4
    } estat_state_e;

    localparam int MODE_W = 3;

endpackage

// File: rtl/estat_mode_fsm.sv
module estat_mode_fsm
    import estat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    output estat_state_e      state_o
);

    estat_state_e state_q;
    estat_state_e state_d;

    // Next state: follow the requested mode; unknown codes fall back to idle
    always_comb begin
        unique case (mode_i)
            3'd1:    state_d = ST_PROG;
            3'd2:    state_d = ST_ERASE;
            3'd3:    state_d = ST_SUSP_RD;
            3'd4:    state_d = ST_SUSP_PG;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/estat_sector_hit.sv
module estat_sector_hit #(
    parameter int NUM_SECTORS = 8,
    localparam int SEC_W = $clog2(NUM_SECTORS)
) (
    input  logic [SEC_W-1:0]       sector_i,
    input  logic [NUM_SECTORS-1:0] mask_i,
    output logic                   hit_o
);

    logic [NUM_SECTORS-1:0] match;

    generate
        for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sec
            assign match[s] = mask_i[s] && (sector_i == SEC_W'(s));
        end
    endgenerate

    assign hit_o = |match;

endmodule

// File: rtl/estat_toggle_ff.sv
module estat_toggle_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic flip_i,
    output logic q_o
);

    logic q_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_q <= 1'b0;
        else if (clr_i)  q_q <= 1'b0;
        else if (flip_i) q_q <= ~q_q;
    end

    assign q_o = q_q;

endmodule

// File: rtl/estat_flags_top.sv
module estat_flags_top
    import estat_pkg::*;
#(
    parameter int NUM_SECTORS = 8,
    localparam int SEC_W = $clog2(NUM_SECTORS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [MODE_W-1:0]      mode_i,
    input  logic                   rd_stb_i,
    input  logic [SEC_W-1:0]       rd_sector_i,
    input  logic [NUM_SECTORS-1:0] erase_mask_i,
    input  logic                   prog_d7_i,
    input  logic                   arr_d7_i,
    input  logic                   arr_d6_i,
    input  logic                   arr_d2_i,
    output logic                   poll_o,
    output logic                   tog1_o,
    output logic                   tog2_o
);

    estat_state_e state;
    logic         stb_q;
    logic         rd_rise;
    logic         sec_hit;
    logic         flip1, flip2, clr_all;
    logic         t1_q, t2_q;

    estat_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .state_o (state)
    );

    estat_sector_hit #(.NUM_SECTORS(NUM_SECTORS)) u_hit (
        .sector_i (rd_sector_i),
        .mask_i   (erase_mask_i),
        .hit_o    (sec_hit)
    );

    // Strobe edge detector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= rd_stb_i;
    end

    assign rd_rise = rd_stb_i && !stb_q;

    // Toggle qualification per state
    always_comb begin
        flip1   = 1'b0;
        flip2   = 1'b0;
        clr_all = 1'b0;
        unique case (state)
            ST_IDLE:    clr_all = 1'b1;
            ST_PROG:    flip1   = rd_rise;
            ST_ERASE: begin
                flip1 = rd_rise;
                flip2 = rd_rise && sec_hit;
            end
            ST_SUSP_RD: flip2   = rd_rise && sec_hit;
            ST_SUSP_PG: flip1   = rd_rise;
            default:    clr_all = 1'b1;
        endcase
    end

    estat_toggle_ff u_tog1 (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_all),
        .flip_i (flip1),
        .q_o    (t1_q)
    );

    estat_toggle_ff u_tog2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_all),
        .flip_i (flip2),
        .q_o    (t2_q)
    );

    // Output selection per state
    always_comb begin
        unique case (state)
            ST_IDLE: begin
                poll_o = arr_d7_i;
                tog1_o = arr_d6_i;
                tog2_o = arr_d2_i;
            end
            ST_PROG: begin
                poll_o = ~prog_d7_i;
                tog1_o = t1_q;
                tog2_o = 1'b1;
            end
            ST_ERASE: begin
                poll_o = 1'b0;
                tog1_o = t1_q;
                tog2_o = t2_q;
            end
            ST_SUSP_RD: begin
                poll_o = 1'b1;
                tog1_o = 1'b1;
                tog2_o = t2_q;
            end
            ST_SUSP_PG: begin
                poll_o = ~prog_d7_i;
                tog1_o = t1_q;
                tog2_o = 1'b1;
            end
            default: begin
                poll_o = arr_d7_i;
                tog1_o = arr_d6_i;
                tog2_o = arr_d2_i;
            end
        endcase
    end

endmodule

// File: rtl/estat_flags_chk.sv
module estat_flags_chk #(
    parameter int NUM_SECTORS = 8,
    localparam int SEC_W = $clog2(NUM_SECTORS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [2:0]             mode_i,
    input logic                   rd_stb_i,
    input logic [SEC_W-1:0]       rd_sector_i,
    input logic [NUM_SECTORS-1:0] erase_mask_i,
    input logic                   prog_d7_i,
    input logic                   poll_o,
    input logic                   tog1_o,
    input logic                   tog2_o
);

    logic [2:0] mode_q;
    logic       stb_q;
    logic       rise;
    logic       hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 3'd0;
            stb_q  <= 1'b0;
        end else begin
            mode_q <= mode_i;
            stb_q  <= rd_stb_i;
        end
    end

    assign rise = rd_stb_i && !stb_q;
    assign hit  = erase_mask_i[rd_sector_i];

    AST_PROG_TOG2_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd1) |-> (tog2_o && (poll_o == !prog_d7_i))); // R3

    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd2) |-> !poll_o); // R4

    AST_ERASE_TOG1_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd2 && $past(mode_q) == 3'd2 && $past(rise))
        |-> (tog1_o != $past(tog1_o))); // R4

    AST_ERASE_TOG1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd2 && $past(mode_q) == 3'd2 && !$past(rise))
        |-> $stable(tog1_o)); // R8

    AST_ERASE_TOG2_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd2 && $past(mode_q) == 3'd2 && !($past(rise) && $past(hit)))
        |-> $stable(tog2_o)); // R5

    AST_SUSP_RD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd3) |-> (poll_o && tog1_o)); // R6

    AST_SUSP_PG_TOG2_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd4) |-> tog2_o); // R7

endmodule

bind estat_flags_top estat_flags_chk #(.NUM_SECTORS(NUM_SECTORS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .rd_stb_i     (rd_stb_i),
    .rd_sector_i  (rd_sector_i),
    .erase_mask_i (erase_mask_i),
    .prog_d7_i    (prog_d7_i),
    .poll_o       (poll_o),
    .tog1_o       (tog1_o),
    .tog2_o       (tog2_o)
);

// File: tb/estat_flags_top_tb_top.sv
`timescale 1ns/1ps
module estat_flags_top_tb_top;

    localparam int NSEC  = 8;
    localparam int SW    = $clog2(NSEC);
    localparam int NVEC  = 17;
    localparam logic [NSEC-1:0] MASK = 8'b0000_0110;

    // {mode[2:0], sector[2:0], prog_d7, arr{d7,d6,d2}, rd, exp{poll,t1,t2}}
    localparam logic [13:0] VECS [NVEC] = '{
        {3'd0, 3'd0, 1'b0, 3'b101, 1'b0, 3'b101},  // R1 idle pass-through
        {3'd1, 3'd0, 1'b1, 3'b000, 1'b1, 3'b011},  // R3 program read
        {3'd1, 3'd0, 1'b0, 3'b000, 1'b1, 3'b101},  // R3
        {3'd1, 3'd0, 1'b1, 3'b000, 1'b0, 3'b001},  // R3 no read
        {3'd0, 3'd0, 1'b0, 3'b010, 1'b0, 3'b010},  // R9 idle clear
        {3'd2, 3'd1, 1'b0, 3'b000, 1'b1, 3'b011},  // R4 R5 hit
        {3'd2, 3'd2, 1'b0, 3'b000, 1'b1, 3'b000},  // R5 hit
        {3'd2, 3'd0, 1'b0, 3'b000, 1'b1, 3'b010},  // R5 miss holds
        {3'd3, 3'd1, 1'b0, 3'b000, 1'b1, 3'b111},  // R6 hit
        {3'd3, 3'd1, 1'b0, 3'b000, 1'b1, 3'b110},  // R6
        {3'd3, 3'd3, 1'b0, 3'b000, 1'b1, 3'b110},  // R6 miss
        {3'd4, 3'd5, 1'b0, 3'b000, 1'b1, 3'b101},  // R7 R10
        {3'd4, 3'd5, 1'b1, 3'b000, 1'b1, 3'b011},  // R7
        {3'd2, 3'd0, 1'b0, 3'b000, 1'b0, 3'b010},  // R10 resume
        {3'd2, 3'd2, 1'b0, 3'b000, 1'b1, 3'b001},  // R4 R5
        {3'd0, 3'd0, 1'b0, 3'b111, 1'b0, 3'b111},  // R1 R9
        {3'd1, 3'd0, 1'b0, 3'b000, 1'b1, 3'b111}   // R9 cleared first read
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic [2:0]      mode;
    logic            stb;
    logic [SW-1:0]   sector;
    logic [NSEC-1:0] mask;
    logic            d7p, a7, a6, a2;
    logic            poll, t1, t2;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    estat_flags_top #(.NUM_SECTORS(NSEC)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode),
        .rd_stb_i     (stb),
        .rd_sector_i  (sector),
        .erase_mask_i (mask),
        .prog_d7_i    (d7p),
        .arr_d7_i     (a7),
        .arr_d6_i     (a6),
        .arr_d2_i     (a2),
        .poll_o       (poll),
        .tog1_o       (t1),
        .tog2_o       (t2)
    );

    task automatic check(input string req, input logic [2:0] exp);
        n_chk++;
        if ({poll, t1, t2} !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, {poll, t1, t2}, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode = 3'd0; stb = 1'b0; sector = '0; mask = MASK;
        d7p = 1'b0; {a7, a6, a2} = 3'b011;
        repeat (3) @(negedge clk);
        check("R1 reset", 3'b011);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 3'b011);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            mode   = VECS[i][13:11];
            sector = VECS[i][10:8];
            d7p    = VECS[i][7];
            {a7, a6, a2} = VECS[i][6:4];
            stb    = 1'b0;
            @(negedge clk);
            stb    = VECS[i][3];
            @(negedge clk);
            check($sformatf("R3-table step %0d", i), VECS[i][2:0]);
            stb    = 1'b0;
        end

        // R2: mode change latency, back to idle first
        mode = 3'd0; {a7, a6, a2} = 3'b000;
        @(negedge clk);
        mode = 3'd1; d7p = 1'b0;
        #1;
        check("R2 before edge", 3'b000);
        @(negedge clk);
        check("R2 after edge", 3'b101);

        // R8: held strobe inverts once
        stb = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 held strobe", 3'b111);
        stb = 1'b0;
        @(negedge clk);
        check("R8 strobe released", 3'b111);
        stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
        check("R8 second pulse", 3'b101);

        // R2: illegal code acts as idle
        mode = 3'd6; {a7, a6, a2} = 3'b110;
        @(negedge clk);
        check("R2 illegal code", 3'b110);

        // R9: after idle, erase read starts from zero
        mode = 3'd2; sector = 3'd1;
        @(negedge clk);
        stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
        check("R9 erase from cleared", 3'b011);

        // R1: asynchronous reset mid-erase clears toggle state
        rst_n = 1'b0;
        #1;
        check("R1 reset mid-op", 3'b110);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
        check("R1 toggles cleared by reset", 3'b011);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule